// File: doc/BRIEF.md
# Paged SPI EEPROM Word Writer

This block writes a run of 16-bit words into a serial EEPROM that speaks the common SPI command set. A host gives a starting word offset and a word count with a one-cycle start pulse. The block checks that the run fits inside the device, then drives chip select, serial clock and the data line itself, reading the device's data-out line when it has to. While it runs it asks for each data word through a fetch port: it presents the index of the word inside the run and takes the word on the same cycle.

The run is split on device page boundaries. Each page begins with a poll of the device status register, repeated until the busy bit clears or a retry limit is reached. A write-enable command follows in its own select frame. A write frame then carries the opcode, the byte address and as many words as fit before the next page boundary. Devices with eight address bits take the ninth byte-address bit inside the opcode. When the run ends, a one-cycle done pulse is given, and the error flag is valid in that same cycle.

The serial clock high and low times come from a run-time half-period input. A value of zero counts as one cycle.

Top module: `spw_page_writer`

## Requirements
- R1: A start with offset >= WORD_SIZE, count of zero, or count > WORD_SIZE - offset ends with done and err_o high, and chip select never falls.
- R2: Each page begins with status polls. A poll is one select frame: opcode 0x05 sent, then 8 bits read MSB first. The page goes on only after a poll whose last bit read (status bit 0) is 0.
- R3: After STAT_TRIES polls that all read status bit 0 as 1, the run ends with err_o high. No further frame is sent.
- R4: A frame holding only opcode 0x06 (8 bits) comes between the last poll and the write frame of every page.
- R5: The write opcode is 0x02. When ADDR_BITS is 8 and the page's first word offset is 128 or more, it is 0x0A (bit 3 set).
- R6: After the opcode, the write frame sends the byte address, twice the page's first word offset, as its low ADDR_BITS bits, MSB first.
- R7: Each data word is sent as its low byte and then its high byte, each byte MSB first.
- R8: A write frame ends after the word whose following byte address is a multiple of PAGE_BYTES, or after the last word. The remaining words start a new page sequence.
- R9: While chip select is low, the data line changes only while the clock is low, and each clock high time is exactly max(half_i,1) cycles. While chip select is high, clock and data are low.
- R10: At least max(half_i,1) cycles pass between chip select falling and the first clock rise, and chip select stays high at least that long between frames. The clock is never high while chip select is high.
- R11: done_o is high for exactly one cycle per accepted start, and err_o is valid in that cycle. err_o holds until the next start. A start while busy_o is high has no effect.
- R12: word_idx_o gives the index, within the run, of the word being sent. The word sent for index i is word_i as presented for index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| offset_i | input | OFF_W | First word offset of the run |
| count_i | input | OFF_W | Number of words in the run |
| half_i | input | HALF_W | Serial clock half period in cycles (0 acts as 1) |
| word_idx_o | output | OFF_W | Index within the run of the word being fetched |
| word_i | input | 16 | Data word for word_idx_o |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run failed (range or status timeout), valid with done_o |
| spi_cs_n_o | output | 1 | Device chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Data to the device |
| spi_miso_i | input | 1 | Data from the device |

## Verification
A behavioural device model records every select frame bit by bit and answers status polls with a programmable number of busy replies. Short runs inside one page show opcode, address and byte order. A run that starts mid-page and spans three pages shows where frames are split and that word indices carry across pages. A run that crosses word offset 128 shows the address-flag opcode switching between pages. A run ending at the last word shows address truncation at the device's end. Busy replies below and above the retry limit separate waiting from giving up. Out-of-range requests and a start issued mid-run show that nothing reaches the device. A line monitor runs throughout at several half periods and checks clock high times and select spacing.

// File: rtl/spw_pkg.sv
// Shared opcodes and state encodings for the paged SPI EEPROM writer.
// Assumes a device using the common single-byte SPI command set.
package spw_pkg;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_WR_EN  = 8'h06;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_HI_ADR = 8'h08;

    typedef enum logic [3:0] {
        S_IDLE, S_ST_SETUP, S_ST_OP, S_ST_RD, S_ST_GAP,
        S_WE_SETUP, S_WE_OP, S_WE_GAP,
        S_WR_SETUP, S_WR_OP, S_WR_ADDR, S_WR_DATA, S_WR_GAP, S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {E_IDLE, E_LO, E_HI, E_TAIL} eng_state_t;
endpackage

// File: rtl/spw_range_chk.sv
// Decides whether a requested run fits inside the device.
// Assumes offset and count are unsigned word quantities.
module spw_range_chk #(
    parameter int WORD_SIZE = 256,
    parameter int OFF_W     = 9
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [OFF_W-1:0] cnt_i,
    output logic             bad_o
);
    localparam int CW = OFF_W + 2;
    logic [CW-1:0] off_x, cnt_x, lim_x;

    // Widen operands and apply the three rejection rules.
    always_comb begin
        off_x = CW'(off_i);
        cnt_x = CW'(cnt_i);
        lim_x = CW'(WORD_SIZE);
        bad_o = (off_x >= lim_x) || (cnt_x == '0) || (cnt_x > (lim_x - off_x));
    end
endmodule

// File: rtl/spw_bit_engine.sv
// Shifts up to 16 bits out MSB first, or clocks bits in, with a
// programmable half period. Each bit: data set while the clock is low,
// clock high, device output sampled at the end of the high phase. A
// closing low phase with data low follows the last bit; done pulses after it.
// Assumes the caller does not pulse go_i while a transfer is running.
module spw_bit_engine
    import spw_pkg::*;
#(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [4:0]        nbits_i,
    input  logic [15:0]       data_i,
    input  logic              rx_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic              rx_last_o
);
    eng_state_t        st;
    logic [HALF_W-1:0] tmr, hm1;
    logic [4:0]        left;
    logic [15:0]       shreg, aligned;
    logic              rxmode, mosi_q, sck_q, done_q, last_q;

    // Phase length minus one; a zero half period behaves as one.
    always_comb begin
        hm1     = (half_i == '0) ? '0 : half_i - 1'b1;
        aligned = data_i << (5'd16 - nbits_i);
    end

    // Bit sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= E_IDLE; tmr <= '0; left <= '0; shreg <= '0;
            rxmode <= 1'b0; mosi_q <= 1'b0; sck_q <= 1'b0;
            done_q <= 1'b0; last_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                E_IDLE: if (go_i) begin
                    shreg  <= aligned;
                    left   <= nbits_i;
                    rxmode <= rx_i;
                    mosi_q <= rx_i ? 1'b0 : aligned[15];
                    tmr    <= hm1;
                    st     <= E_LO;
                end
                E_LO: if (tmr == '0) begin
                    sck_q <= 1'b1; tmr <= hm1; st <= E_HI;
                end else tmr <= tmr - 1'b1;
                E_HI: if (tmr == '0) begin
                    sck_q  <= 1'b0;
                    last_q <= miso_i;
                    shreg  <= shreg << 1;
                    left   <= left - 1'b1;
                    tmr    <= hm1;
                    if (left == 5'd1) begin
                        mosi_q <= 1'b0; st <= E_TAIL;
                    end else begin
                        mosi_q <= rxmode ? 1'b0 : shreg[14]; st <= E_LO;
                    end
                end else tmr <= tmr - 1'b1;
                default: if (tmr == '0) begin
                    done_q <= 1'b1; st <= E_IDLE;
                end else tmr <= tmr - 1'b1;
            endcase
        end
    end

    assign sck_o     = sck_q;
    assign mosi_o    = mosi_q;
    assign done_o    = done_q;
    assign rx_last_o = last_q;

    // R9: data must not move while the clock is held high.
    a_r9_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi_q));
    // R9: after the last bit the data line returns low with the clock.
    a_r9_tail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!mosi_q && !sck_q));
endmodule

// File: rtl/spw_page_writer.sv
// Writes a run of 16-bit words to an SPI EEPROM, page by page: status
// poll, write enable, then write frame with byte address and byte-swapped
// words until a page boundary. Chip select is low only inside frames and
// is framed by one half period on each side.
// Assumes PAGE_BYTES is a power of two and ADDR_BITS <= 16.
module spw_page_writer
    import spw_pkg::*;
#(
    parameter int WORD_SIZE  = 256,
    parameter int ADDR_BITS  = 8,
    parameter int PAGE_BYTES = 16,
    parameter int STAT_TRIES = 4,
    parameter int HALF_W     = 4,
    parameter int OFF_W      = $clog2(WORD_SIZE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [OFF_W-1:0]  count_i,
    input  logic [HALF_W-1:0] half_i,
    output logic [OFF_W-1:0]  word_idx_o,
    input  logic [15:0]       word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              spi_cs_n_o,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);
    localparam int PB_LG = $clog2(PAGE_BYTES);
    localparam int TRY_W = $clog2(STAT_TRIES + 1);

    seq_state_t        st;
    logic [OFF_W-1:0]  woff, rem, idx;
    logic [HALF_W-1:0] tmr, hm1;
    logic [TRY_W-1:0]  tries;
    logic              stat_ok, fail_q, go_q, done_q, err_q, range_bad;
    logic              eng_done, eng_last, eng_rx;
    logic [4:0]        eng_nbits;
    logic [15:0]       eng_data;
    logic [7:0]        wr_op;
    logic [OFF_W:0]    next_ba;
    logic              page_end;

    spw_range_chk #(.WORD_SIZE(WORD_SIZE), .OFF_W(OFF_W)) range_i (
        .off_i(offset_i), .cnt_i(count_i), .bad_o(range_bad));

    spw_bit_engine #(.HALF_W(HALF_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .go_i(go_q), .nbits_i(eng_nbits),
        .data_i(eng_data), .rx_i(eng_rx), .half_i(half_i),
        .miso_i(spi_miso_i), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o),
        .done_o(eng_done), .rx_last_o(eng_last));

    // Opcode with high address flag, page boundary test and phase length.
    always_comb begin
        hm1      = (half_i == '0) ? '0 : half_i - 1'b1;
        wr_op    = OP_WRITE;
        if ((ADDR_BITS == 8) && (32'(woff) >= 32'd128)) wr_op = OP_WRITE | OP_HI_ADR;
        next_ba  = {woff + 1'b1, 1'b0};
        page_end = (next_ba[PB_LG-1:0] == '0);
    end

    // Select what the engine shifts in the current state.
    always_comb begin
        eng_nbits = 5'd8;
        eng_rx    = 1'b0;
        eng_data  = 16'h0000;
        case (st)
            S_ST_OP:   eng_data = {8'h00, OP_STATUS};
            S_ST_RD:   eng_rx   = 1'b1;
            S_WE_OP:   eng_data = {8'h00, OP_WR_EN};
            S_WR_OP:   eng_data = {8'h00, wr_op};
            S_WR_ADDR: begin
                eng_nbits = 5'(ADDR_BITS);
                eng_data  = 16'({woff, 1'b0});
            end
            S_WR_DATA: begin
                eng_nbits = 5'd16;
                eng_data  = {word_i[7:0], word_i[15:8]};
            end
            default: ;
        endcase
    end

    // Page sequencing: poll, enable, write, split, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; woff <= '0; rem <= '0; idx <= '0; tmr <= '0;
            tries <= '0; stat_ok <= 1'b0; fail_q <= 1'b0; go_q <= 1'b0;
            done_q <= 1'b0; err_q <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    err_q <= 1'b0; fail_q <= range_bad;
                    woff <= offset_i; rem <= count_i; idx <= '0; tries <= '0;
                    tmr <= hm1;
                    st <= range_bad ? S_FINISH : S_ST_SETUP;
                end
                S_ST_SETUP, S_WE_SETUP, S_WR_SETUP: if (tmr == '0) begin
                    go_q <= 1'b1;
                    st <= (st == S_ST_SETUP) ? S_ST_OP :
                          (st == S_WE_SETUP) ? S_WE_OP : S_WR_OP;
                end else tmr <= tmr - 1'b1;
                S_ST_OP:   if (eng_done) begin go_q <= 1'b1; st <= S_ST_RD; end
                S_ST_RD:   if (eng_done) begin
                    tries <= tries + 1'b1; stat_ok <= !eng_last;
                    tmr <= hm1; st <= S_ST_GAP;
                end
                S_ST_GAP:  if (tmr == '0) begin
                    tmr <= hm1;
                    if (stat_ok) st <= S_WE_SETUP;
                    else if (tries == TRY_W'(STAT_TRIES)) begin
                        fail_q <= 1'b1; st <= S_FINISH;
                    end else st <= S_ST_SETUP;
                end else tmr <= tmr - 1'b1;
                S_WE_OP:   if (eng_done) begin tmr <= hm1; st <= S_WE_GAP; end
                S_WE_GAP:  if (tmr == '0) begin tmr <= hm1; st <= S_WR_SETUP; end
                           else tmr <= tmr - 1'b1;
                S_WR_OP:   if (eng_done) begin go_q <= 1'b1; st <= S_WR_ADDR; end
                S_WR_ADDR: if (eng_done) begin go_q <= 1'b1; st <= S_WR_DATA; end
                S_WR_DATA: if (eng_done) begin
                    idx <= idx + 1'b1; woff <= woff + 1'b1; rem <= rem - 1'b1;
                    if ((rem == OFF_W'(1)) || page_end) begin
                        tmr <= hm1; st <= S_WR_GAP;
                    end else go_q <= 1'b1;
                end
                S_WR_GAP:  if (tmr == '0) begin
                    tmr <= hm1; tries <= '0;
                    st <= (rem == '0) ? S_FINISH : S_ST_SETUP;
                end else tmr <= tmr - 1'b1;
                default: begin
                    done_q <= 1'b1; err_q <= fail_q; st <= S_IDLE;
                end
            endcase
        end
    end

    assign spi_cs_n_o = !((st == S_ST_SETUP) || (st == S_ST_OP) || (st == S_ST_RD) ||
                          (st == S_WE_SETUP) || (st == S_WE_OP) ||
                          (st == S_WR_SETUP) || (st == S_WR_OP) ||
                          (st == S_WR_ADDR)  || (st == S_WR_DATA));
    assign busy_o     = (st != S_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign word_idx_o = idx;

    // R9: lines are quiet whenever the device is deselected.
    a_r9_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> (!spi_sck_o && !spi_mosi_o));
    // R10: the clock only runs inside a select frame.
    a_r10_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck_o |-> !spi_cs_n_o);
    // R1: a rejected request finishes without selecting the device.
    a_r1_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && range_bad) |=> spi_cs_n_o ##1 (done_o && err_o));
    // R11: the done pulse lasts one cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: the error flag holds while idle with no new start.
    a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));
endmodule

// File: tb/spw_page_writer_tb_top.sv
`timescale 1ns/1ps
// Directed bench: behavioural SPI EEPROM model, frame recorder, line monitor.
module spw_page_writer_tb_top;
    localparam int WS = 256, AB = 8, PB = 16, TRIES = 4, HW = 4, OW = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start_i, spi_miso_i;
    logic [OW-1:0] offset_i, count_i, word_idx_o;
    logic [HW-1:0] half_i;
    logic [15:0]   word_i;
    logic          busy_o, done_o, err_o, spi_cs_n_o, spi_sck_o, spi_mosi_o;

    int total = 0, bad = 0, base_q = 0, cyc = 0;

    function automatic logic [15:0] pat(int b, int i);
        return 16'(32'hA55A ^ (b * 977 + i * 4099));
    endfunction

    assign word_i = pat(base_q, int'(word_idx_o));

    spw_page_writer #(.WORD_SIZE(WS), .ADDR_BITS(AB), .PAGE_BYTES(PB),
        .STAT_TRIES(TRIES), .HALF_W(HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
        .count_i(count_i), .half_i(half_i), .word_idx_o(word_idx_o),
        .word_i(word_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o),
        .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i));

    // Device model and line monitor, evaluated away from the active edge.
    logic [7:0] fbyte [0:63][0:39];
    int         fbits [0:63];
    logic [7:0] cur [0:39];
    int curbits = 0, nframes = 0, busy_left = 0, hp = 1, tviol = 0;
    int hi_run = 0, lo_run = 0, csh_run = 1000;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
    logic [7:0] stat_byte;

    initial spi_miso_i = 1'b0;

    always @(negedge clk) begin
        stat_byte = (busy_left > 0) ? 8'h03 : 8'h02;
        if (spi_cs_n_o) begin
            if (spi_sck_o || spi_mosi_o) tviol++;
            if (!prev_cs && nframes < 64) begin
                fbits[nframes] = curbits;
                for (int k = 0; k < 40; k++) fbyte[nframes][k] = cur[k];
                if (cur[0] == 8'h05 && busy_left > 0) busy_left--;
                nframes++;
            end
            if (!prev_cs) nframes = (nframes > 64) ? 64 : nframes;
            csh_run++;
            spi_miso_i = 1'b0;
        end else begin
            if (prev_cs) begin
                if (csh_run < hp) tviol++;
                csh_run = 0; lo_run = 0; curbits = 0;
                for (int k = 0; k < 40; k++) cur[k] = 8'h00;
            end
            if (spi_sck_o && !prev_sck) begin
                if (lo_run < hp) tviol++;
                hi_run = 0;
                if (curbits < 320) cur[curbits/8] = {cur[curbits/8][6:0], spi_mosi_o};
                curbits++;
            end
            if (spi_sck_o) begin
                hi_run++;
                if (prev_sck && spi_mosi_o != prev_mosi) tviol++;
            end
            if (!spi_sck_o && prev_sck) begin
                if (hi_run != hp) tviol++;
                lo_run = 0;
                if (curbits >= 8 && curbits < 16 && cur[0] == 8'h05)
                    spi_miso_i = stat_byte[15 - curbits];
                else spi_miso_i = 1'b0;
            end
            if (!spi_sck_o) lo_run++;
        end
        prev_cs = spi_cs_n_o; prev_sck = spi_sck_o; prev_mosi = spi_mosi_o;
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int last_err = 0;

    // Run one request; optionally issue a second start mid-run.
    task automatic run_write(int off, int cnt, int half, int busy, int b, bit poke);
        bit seen = 0;
        @(negedge clk);
        nframes = 0; tviol = 0; busy_left = busy; base_q = b;
        hp = (half == 0) ? 1 : half; half_i = HW'(half);
        offset_i = OW'(off); count_i = OW'(cnt); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 60000; k++) begin
            if (poke && k == 30) begin
                offset_i = OW'(100); count_i = OW'(50); start_i = 1'b1;
            end
            if (poke && k == 31) start_i = 1'b0;
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
        end
        check("R11 done seen", int'(seen), 1);
        last_err = int'(err_o);
        @(negedge clk);
        check("R11 done one cycle", int'(done_o), 0);
        check("R9 R10 line timing violations", tviol, 0);
    endtask

    // Walk the recorded frames against the page rules.
    task automatic expect_frames(int off, int cnt, int busy, int b);
        int j = 0, woff = off, rem = cnt, polls, n;
        logic [15:0] w;
        bit first = 1;
        while (rem > 0 && j < 60) begin
            polls = first ? busy + 1 : 1;
            first = 0;
            for (int p = 0; p < polls; p++) begin
                check("R2 poll frame bits", fbits[j], 16);
                check("R2 poll opcode", int'(fbyte[j][0]), 8'h05);
                j++;
            end
            check("R4 enable frame bits", fbits[j], 8);
            check("R4 enable opcode", int'(fbyte[j][0]), 8'h06);
            j++;
            n = (PB - ((2 * woff) % PB)) / 2;
            if (n > rem) n = rem;
            check("R8 write frame bits", fbits[j], 8 + AB + 16 * n);
            check("R5 write opcode", int'(fbyte[j][0]), (woff >= 128) ? 8'h0A : 8'h02);
            check("R6 byte address", int'(fbyte[j][1]), (2 * woff) & 8'hFF);
            for (int i = 0; i < n; i++) begin
                w = pat(b, cnt - rem + i);
                check("R7 R12 low byte first", int'(fbyte[j][2 + 2*i]), int'(w[7:0]));
                check("R7 R12 high byte second", int'(fbyte[j][3 + 2*i]), int'(w[15:8]));
            end
            j++; woff += n; rem -= n;
        end
        check("R8 frame count", nframes, j);
    endtask

    task automatic t_reset();
        check("R11 reset busy", int'(busy_o), 0);
        check("R11 reset done", int'(done_o), 0);
        check("R11 reset err", int'(err_o), 0);
        check("R9 reset cs_n", int'(spi_cs_n_o), 1);
        check("R9 reset sck", int'(spi_sck_o), 0);
        check("R9 reset mosi", int'(spi_mosi_o), 0);
    endtask

    task automatic t_reject();
        run_write(256, 1, 2, 0, 1, 0);
        check("R1 offset at size err", last_err, 1);
        check("R1 offset at size silent", nframes, 0);
        run_write(10, 0, 2, 0, 1, 0);
        check("R1 zero count err", last_err, 1);
        check("R1 zero count silent", nframes, 0);
        run_write(250, 7, 2, 0, 1, 0);
        check("R1 overrun err", last_err, 1);
        check("R1 overrun silent", nframes, 0);
    endtask

    task automatic t_single();
        run_write(3, 2, 2, 0, 2, 0);
        check("R2 single page err", last_err, 0);
        expect_frames(3, 2, 0, 2);
    endtask

    task automatic t_poll();
        run_write(0, 1, 1, 2, 3, 0);
        check("R2 busy polls err", last_err, 0);
        expect_frames(0, 1, 2, 3);
    endtask

    task automatic t_timeout();
        run_write(20, 3, 1, 10, 4, 0);
        check("R3 timeout err", last_err, 1);
        check("R3 only polls sent", nframes, TRIES);
        for (int j = 0; j < TRIES; j++)
            check("R3 poll opcode", int'(fbyte[j][0]), 8'h05);
        repeat (20) @(negedge clk);
        check("R11 err held", int'(err_o), 1);
        busy_left = 0;
    endtask

    task automatic t_multi();
        run_write(5, 12, 3, 0, 5, 0);
        check("R8 multi page err", last_err, 0);
        expect_frames(5, 12, 0, 5);
    endtask

    task automatic t_hi_addr();
        run_write(127, 2, 2, 0, 6, 0);
        check("R5 crossing 128 err", last_err, 0);
        expect_frames(127, 2, 0, 6);
        run_write(250, 6, 0, 0, 7, 0);
        check("R6 last words err", last_err, 0);
        expect_frames(250, 6, 0, 7);
    endtask

    task automatic t_ignore();
        run_write(3, 2, 2, 0, 8, 1);
        check("R11 busy start ignored err", last_err, 0);
        expect_frames(3, 2, 0, 8);
        repeat (5) @(negedge clk);
        check("R11 no second run", int'(busy_o), 0);
    endtask

    bit fin = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            fin = 1;
            total++; bad++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; offset_i = '0; count_i = '0; half_i = HW'(2);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_single();
        t_poll();
        t_timeout();
        t_multi();
        t_hi_addr();
        t_ignore();
        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule